// File: doc/BRIEF.md
# Timeslot Interchange Data Memory

This block is the sample store of a PCM timeslot interchanger. Every frame carries 1024 channels, and each channel occupies two clock periods. The block writes each incoming 16-bit sample into a location chosen by an internal frame counter. It reads the outgoing sample from a location named on a 16-bit address bus, which is normally driven by a connection store. This write-in-order, read-by-address scheme moves any input channel to any output channel.

The storage holds 2048 words of 16 bits. In single-buffer operation the write and the read share the lower half, which gives the shortest path through the switch. In double-buffer operation a bank bit selects which half receives the writes, and reads come from the other half. The bank bit flips at every frame start, so an output frame always presents the previous input frame intact. The mode is sampled per timeslot, so single-buffer and double-buffer accesses can be mixed within one frame.

A message option places the latched address word itself on the output bus in place of stored data. An output-enable input and a chip-select input together decide whether the output bus is reported as driven. They do this through a valid flag, not a tristate.

Top module: `tsi_data_mem`

## Requirements
- R1: The 11-bit counter clears to 0 on any rising edge at which `fp_n` is low. Otherwise it increments and wraps from 2047 to 0. Its bits [10:1] give the channel number and bit 0 gives the phase: 0 for the first cycle of a timeslot, 1 for the second.
- R2: `addr_i`, `msg_en`, `out_en`, `chip_sel_n` and the read-side `dbuf_sel` are sampled at the edge that ends the phase-0 cycle of timeslot k. The resulting output appears at the start of timeslot k+1 and holds for both of its cycles.
- R3: `din` is sampled at the edge that ends the phase-1 cycle of its channel. It is written to storage at the next edge. In single-buffer mode (`dbuf_sel`=0) the write location is {0, channel}, and the read location is `addr_i`[10:0], with bits [15:11] ignored.
- R4: In single-buffer mode, an output timeslot at least two after the input channel carries that channel's current-frame sample. An output timeslot fewer than two after the input channel carries the sample from the previous frame.
- R5: In double-buffer mode (`dbuf_sel`=1) the write location is {bank, channel} and the read location is {~bank, `addr_i`[9:0]}, with `addr_i`[10] ignored. The bank bit toggles once at the first edge of each low period of `fp_n`. Reads therefore return samples written in the previous frame.
- R6: `dbuf_sel` is sampled separately for each write (at capture) and for each read (at address latch), so either path may change mode in any timeslot.
- R7: When `msg_en` is sampled high, the next timeslot's `dout` equals the full 16-bit latched `addr_i` word instead of stored data.
- R8: `dout_vld` for timeslot k+1 equals `out_en` AND NOT `chip_sel_n`, both sampled in timeslot k. While `dout_vld` is 0, `dout` reads 0.
- R9: A synchronous active-high `rst` clears the counter, the bank bit, any pending write, `dout_vld` and `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, two periods per timeslot |
| rst | input | 1 | Synchronous reset, active high |
| fp_n | input | 1 | Frame start, active low |
| din | input | 16 | Incoming channel sample |
| addr_i | input | 16 | Read address, or message word |
| dbuf_sel | input | 1 | 1 selects double-buffer addressing |
| msg_en | input | 1 | 1 outputs the address word itself |
| out_en | input | 1 | Output enable |
| chip_sel_n | input | 1 | Chip select, active low |
| dout | output | 16 | Outgoing channel sample |
| dout_vld | output | 1 | Output bus is driven |

## Verification
The assertions check the following on every cycle:
- the counter clear and step rules;
- that writes land only on phase-0 edges;
- that the bank bit moves only after a frame pulse;
- that the output holds across the two cycles of a timeslot;
- that the message word and the drive flag reach the output one timeslot after sampling.

The frame-relative delay split of single-buffer mode, the previous-frame return of double-buffer mode, and the mixing of modes within a frame depend on stored contents across whole frames. Only the bench's frame-long scenarios, checked against its own sample model, can show those behaviours.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    // Channel index width: 2**CH_W channels per frame.
    localparam int CH_W    = 10;
    localparam int DATA_W  = 16;
    localparam int ABUS_W  = 16;
    localparam int CNT_W   = CH_W + 1;
    localparam int MEM_AW  = CH_W + 1;
    localparam int MEM_DEPTH = 1 << MEM_AW;

    // Two clock periods per timeslot.
    typedef enum logic {
        PH_PRE = 1'b0,   // first period: address and control latch, write
        PH_ACC = 1'b1    // second period: storage read, sample capture
    } phase_e;

    // Read-side control captured once per timeslot.
    typedef struct packed {
        logic [ABUS_W-1:0] word;
        logic              msg;
        logic              drive;
        logic              dbuf;
    } rd_ctl_t;

    // Pending write of one captured sample.
    typedef struct packed {
        logic [MEM_AW-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    // Output stage contents for one timeslot.
    typedef struct packed {
        logic [ABUS_W-1:0] word;
        logic              msg;
        logic              vld;
    } out_stage_t;

    function automatic logic [MEM_AW-1:0] wr_loc(
        input logic            dbuf,
        input logic            bank,
        input logic [CH_W-1:0] ch
    );
        return dbuf ? {bank, ch} : {1'b0, ch};
    endfunction

    function automatic logic [MEM_AW-1:0] rd_loc(
        input rd_ctl_t c,
        input logic    bank
    );
        return c.dbuf ? {~bank, c.word[CH_W-1:0]} : c.word[MEM_AW-1:0];
    endfunction

endpackage

// File: rtl/tsi_slot_timer.sv
module tsi_slot_timer
    import tsi_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             fp_n,
    output logic [CNT_W-1:0] cnt,
    output phase_e           phase,
    output logic [CH_W-1:0]  chan,
    output logic             bank
);

    logic fp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            bank <= 1'b0;
            fp_q <= 1'b1;
        end else begin
            fp_q <= fp_n;
            if (!fp_n) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
            // one flip per low period of the frame pulse
            if (!fp_n && fp_q) begin
                bank <= ~bank;
            end
        end
    end

    assign phase = phase_e'(cnt[0]);
    assign chan  = cnt[CNT_W-1:1];

endmodule

// File: rtl/tsi_wr_path.sv
module tsi_wr_path
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic [CH_W-1:0]   chan,
    input  logic              bank,
    input  logic              dbuf_sel,
    input  logic [DATA_W-1:0] din,
    output logic              wr_en,
    output wr_req_t           wr_req
);

    logic pend_vld;

    // Capture at the end of the access period, commit on the next edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_vld <= 1'b0;
            wr_req   <= '0;
        end else if (phase == PH_ACC) begin
            pend_vld    <= 1'b1;
            wr_req.addr <= wr_loc(dbuf_sel, bank, chan);
            wr_req.data <= din;
        end
    end

    assign wr_en = pend_vld && (phase == PH_PRE);

endmodule

// File: rtl/tsi_rd_path.sv
module tsi_rd_path
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_e            phase,
    input  logic              bank,
    input  logic [ABUS_W-1:0] addr_i,
    input  logic              msg_en,
    input  logic              out_en,
    input  logic              chip_sel_n,
    input  logic              dbuf_sel,
    output rd_ctl_t           ctl,
    output logic              rd_en,
    output logic [MEM_AW-1:0] rd_addr,
    output out_stage_t        ostage
);

    // Latch address and controls on the first edge of a timeslot.
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (phase == PH_PRE) begin
            ctl.word  <= addr_i;
            ctl.msg   <= msg_en;
            ctl.drive <= out_en && !chip_sel_n;
            ctl.dbuf  <= dbuf_sel;
        end
    end

    assign rd_en   = (phase == PH_ACC);
    assign rd_addr = rd_loc(ctl, bank);

    // Output stage moves at the timeslot boundary, alongside the storage read.
    always_ff @(posedge clk) begin
        if (rst) begin
            ostage <= '0;
        end else if (phase == PH_ACC) begin
            ostage.word <= ctl.word;
            ostage.msg  <= ctl.msg;
            ostage.vld  <= ctl.drive;
        end
    end

endmodule

// File: rtl/tsi_store.sv
module tsi_store
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              we,
    input  logic [MEM_AW-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [MEM_AW-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        if (re) begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/tsi_data_mem.sv
module tsi_data_mem
    import tsi_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              fp_n,
    input  logic [DATA_W-1:0] din,
    input  logic [ABUS_W-1:0] addr_i,
    input  logic              dbuf_sel,
    input  logic              msg_en,
    input  logic              out_en,
    input  logic              chip_sel_n,
    output logic [DATA_W-1:0] dout,
    output logic              dout_vld
);

    logic [CNT_W-1:0]  cnt;
    phase_e            phase;
    logic [CH_W-1:0]   chan;
    logic              bank;
    logic              wr_en;
    wr_req_t           wr_req;
    rd_ctl_t           rd_ctl;
    logic              rd_en;
    logic [MEM_AW-1:0] rd_addr;
    out_stage_t        ostage;
    logic [DATA_W-1:0] mem_q;

    tsi_slot_timer u_timer (
        .clk   (clk),
        .rst   (rst),
        .fp_n  (fp_n),
        .cnt   (cnt),
        .phase (phase),
        .chan  (chan),
        .bank  (bank)
    );

    tsi_wr_path u_wr (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .chan     (chan),
        .bank     (bank),
        .dbuf_sel (dbuf_sel),
        .din      (din),
        .wr_en    (wr_en),
        .wr_req   (wr_req)
    );

    tsi_rd_path u_rd (
        .clk        (clk),
        .rst        (rst),
        .phase      (phase),
        .bank       (bank),
        .addr_i     (addr_i),
        .msg_en     (msg_en),
        .out_en     (out_en),
        .chip_sel_n (chip_sel_n),
        .dbuf_sel   (dbuf_sel),
        .ctl        (rd_ctl),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .ostage     (ostage)
    );

    tsi_store u_store (
        .clk   (clk),
        .we    (wr_en),
        .waddr (wr_req.addr),
        .wdata (wr_req.data),
        .re    (rd_en),
        .raddr (rd_addr),
        .rdata (mem_q)
    );

    always_comb begin
        if (!ostage.vld) begin
            dout = '0;
        end else if (ostage.msg) begin
            dout = ostage.word[DATA_W-1:0];
        end else begin
            dout = mem_q;
        end
    end

    assign dout_vld = ostage.vld;

endmodule

// File: rtl/tsi_data_mem_chk.sv
module tsi_data_mem_chk
    import tsi_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fp_n,
    input logic [CNT_W-1:0]  cnt,
    input logic              bank,
    input logic              wr_en,
    input rd_ctl_t           ctl,
    input logic [DATA_W-1:0] dout,
    input logic              dout_vld
);

    // R1
    cnt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !fp_n |=> (cnt == '0));

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        fp_n |=> (cnt == $past(cnt) + 1'b1));

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cnt[0] |-> ($stable(dout) && $stable(dout_vld)));

    // R3
    wr_phase_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !cnt[0]);

    // R5
    bank_flip_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(bank) |-> $past(!fp_n));

    // R7
    msg_out_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt[0] && ctl.msg && ctl.drive) |=> (dout == $past(ctl.word)));

    // R8
    vld_src_chk: assert property (@(posedge clk) disable iff (rst)
        cnt[0] |=> (dout_vld == $past(ctl.drive)));

endmodule

bind tsi_data_mem tsi_data_mem_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .fp_n     (fp_n),
    .cnt      (cnt),
    .bank     (bank),
    .wr_en    (wr_en),
    .ctl      (rd_ctl),
    .dout     (dout),
    .dout_vld (dout_vld)
);

// File: tb/tsi_data_mem_bench.sv
module tsi_data_mem_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fp_n = 1'b1;
    logic [15:0] din = '0;
    logic [15:0] addr_i = '0;
    logic        dbuf_sel = 1'b0;
    logic        msg_en = 1'b0;
    logic        out_en = 1'b0;
    logic        chip_sel_n = 1'b1;
    logic [15:0] dout;
    logic        dout_vld;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tsi_data_mem u_tsi_data_mem (
        .clk        (clk),
        .rst        (rst),
        .fp_n       (fp_n),
        .din        (din),
        .addr_i     (addr_i),
        .dbuf_sel   (dbuf_sel),
        .msg_en     (msg_en),
        .out_en     (out_en),
        .chip_sel_n (chip_sel_n),
        .dout       (dout),
        .dout_vld   (dout_vld)
    );

    // Sample model built from the requirements.
    logic [15:0] m_mem [2048];
    logic [10:0] m_cnt;
    bit          m_bank, m_fpq, m_pv;
    logic [10:0] m_paddr;
    logic [15:0] m_pdata;
    logic [15:0] m_cword;
    bit          m_cmsg, m_cdrv, m_cdbuf;
    logic [15:0] m_oword, m_omem;
    bit          m_omsg, m_ovld;

    // Per-timeslot stimulus record.
    logic [15:0] addr_of [1024];
    bit          ms_of [1024];
    bit          dv_of [1024];

    function automatic logic [15:0] m_dout();
        if (!m_ovld) return 16'h0;
        if (m_omsg) return m_oword;
        return m_omem;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (time %0t)", req, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = '0; m_bank = 1'b0; m_fpq = 1'b1; m_pv = 1'b0;
        m_paddr = '0; m_pdata = '0;
        m_cword = '0; m_cmsg = 1'b0; m_cdrv = 1'b0; m_cdbuf = 1'b0;
        m_oword = '0; m_omem = '0; m_omsg = 1'b0; m_ovld = 1'b0;
    endtask

    task automatic model_step(input bit fpa, input logic [15:0] d, input logic [15:0] a,
                              input bit db, input bit ms, input bit oe, input bit cs_n);
        logic [9:0]  ch;
        logic [10:0] ra;
        ch = m_cnt[10:1];
        if (m_cnt[0] == 1'b0) begin
            if (m_pv) m_mem[m_paddr] = m_pdata;
            m_cword = a; m_cmsg = ms; m_cdrv = oe && !cs_n; m_cdbuf = db;
        end else begin
            ra = m_cdbuf ? {~m_bank, m_cword[9:0]} : m_cword[10:0];
            m_omem = m_mem[ra];
            m_oword = m_cword; m_omsg = m_cmsg; m_ovld = m_cdrv;
            m_pv = 1'b1;
            m_paddr = db ? {m_bank, ch} : {1'b0, ch};
            m_pdata = d;
        end
        if (fpa && m_fpq) m_bank = ~m_bank;
        m_fpq = !fpa;
        m_cnt = fpa ? 11'd0 : m_cnt + 11'd1;
    endtask

    // One cycle: compare outputs of the current cycle, drive next inputs, advance.
    task automatic cyc(input bit fpa, input logic [15:0] d, input logic [15:0] a,
                       input bit db, input bit ms, input bit oe, input bit cs_n,
                       input string tag, input bit dchk, input string dtag,
                       input logic [15:0] dexp);
        check("R8", {15'b0, dout_vld}, {15'b0, m_ovld});
        check((m_ovld && m_omsg) ? "R7" : tag, dout, m_dout());
        if (dchk) check(dtag, dout, dexp);
        fp_n = !fpa; din = d; addr_i = a; dbuf_sel = db;
        msg_en = ms; out_en = oe; chip_sel_n = cs_n;
        model_step(fpa, d, a, db, ms, oe, cs_n);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [10:0] c;
        logic [9:0]  k;
        logic [9:0]  kp;
        logic [15:0] ap;
        logic [15:0] a;
        logic [15:0] d;
        bit          db, ms, oe, csn, dchk;
        logic [15:0] dexp;
        string       tag, dtag;

        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 1024; i++) begin
            addr_of[i] = '0; ms_of[i] = 1'b0; dv_of[i] = 1'b0;
        end
        repeat (4) @(negedge clk);
        model_reset();
        // R9: outputs cleared by reset
        check("R9", dout, 16'h0);
        check("R9", {15'b0, dout_vld}, 16'h0);
        rst = 1'b0;

        for (int fr = 0; fr < 10; fr++) begin
            int ncyc;
            ncyc = (fr == 9) ? 4500 : 2048;
            for (int i = 0; i < ncyc; i++) begin
                c = m_cnt;
                k = c[10:1];
                dchk = 1'b0; dexp = '0; dtag = "";
                ms = 1'b0; csn = 1'b0; oe = 1'b1;
                d = {fr[3:0], 2'b00, k};
                if (fr < 2) begin
                    // fill both halves, output disabled
                    db = 1'b1; oe = 1'b0; tag = "R8";
                    if (!c[0]) addr_of[k] = 16'($urandom);
                    a = addr_of[k];
                end else if (fr < 5) begin
                    db = 1'b0; tag = "R3";
                    a = k[0] ? {6'b0, k - 10'd1} : {6'b0, k};
                    addr_of[k] = a;
                    if (fr == 4 && c[0] && c >= 11'd3) begin
                        // R4: address from timeslot kp shows in this one
                        kp = k - 10'd1;
                        ap = addr_of[kp];
                        dchk = 1'b1; dtag = "R4";
                        dexp = (ap[9:0] == kp) ? (16'h3000 + {6'b0, kp})
                                               : (16'h4000 + ap);
                    end
                end else if (fr < 8) begin
                    db = 1'b1; tag = "R5";
                    if (!c[0]) addr_of[k] = 16'($urandom);
                    a = addr_of[k];
                    if (fr == 7 && c[0] && c >= 11'd3) begin
                        // R5: previous frame sample, bit 10 ignored
                        kp = k - 10'd1;
                        dchk = 1'b1; dtag = "R5";
                        dexp = 16'h6000 + {6'b0, addr_of[kp][9:0]};
                    end
                end else begin
                    // R6: mode changes per cycle; random controls
                    tag = (fr == 8) ? "R6" : "R1";
                    d = 16'($urandom);
                    db = ($urandom % 2) == 0;
                    if (fr == 8 && !c[0] && c >= 11'd2) begin
                        kp = k - 10'd1;
                        if (ms_of[kp] && dv_of[kp]) begin
                            dchk = 1'b1; dtag = "R7"; dexp = addr_of[kp];
                        end
                    end
                    if (!c[0]) begin
                        addr_of[k] = 16'($urandom);
                        ms_of[k] = ($urandom % 4) == 0;
                        oe = ($urandom % 4) != 0;
                        csn = ($urandom % 8) == 0;
                        dv_of[k] = oe && !csn;
                    end else begin
                        oe = dv_of[k]; csn = 1'b0;
                    end
                    a = addr_of[k];
                    ms = ms_of[k];
                end
                cyc((c == 11'd2047) || (fr == 9 && i >= 700 && i < 703),
                    d, a, db, ms, oe, csn, tag, dchk, dtag, dexp);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule